// File: doc/BRIEF.md
# USB Endpoint Prime/Flush Controller

This block turns software requests into per-endpoint work for a USB device-mode core with four endpoints, each with a transmit lane and a receive lane. Software writes one-bits into a prime register to ask that an endpoint fetch its next transfer descriptor and get a buffer ready. Software writes one-bits into a flush register to throw away a buffer that is already prepared. The hardware clears each request bit once the work is done, so software can poll a bit until it reads zero.

Prime requests go to a descriptor-fetch engine over a request/acknowledge handshake, one lane at a time, in a fixed priority order. An acknowledge means the lane is primed. The block keeps a primed-status vector that software can read. A flush waits while the packet engine reports a packet in flight on that lane, and it also waits while a fetch for that lane is outstanding. When the descriptor engine retires a descriptor, the block raises that lane's prime bit again, so the lane re-primes on its own.

Top module: `epreq_top`

## Requirements
- R1: After reset, the prime, flush and status registers read zero and `fetchReq` is low.
- R2: The register at word address 0 is prime, at 1 is flush and at 2 is status. Receive endpoint e sits at bit e and transmit endpoint e at bit 16+e. All other bits read zero, and any other address reads zero.
- R3: Writing a one to a prime bit sets it. Writing a zero leaves the bit unchanged. Writes to the status address change nothing.
- R4: While `fetchReq` is high without `fetchAck`, the request and its `fetchEp`/`fetchIsTx` hold steady. On the acknowledge edge the lane's prime bit clears, its status bit sets, and `fetchReq` is low in the next cycle.
- R5: Pending prime bits are served lowest endpoint first, with transmit before receive at the same endpoint.
- R6: A flush pending on a lane that has no packet in flight and no outstanding fetch pulses that lane's discard output (`flushTx`/`flushRx`) for that cycle. At the next edge it clears the lane's flush, prime and status bits.
- R7: While the packet engine marks a lane busy, a flush on that lane stays pending and nothing is discarded.
- R8: A lane with a pending flush is never offered to the fetch engine. Its prime bit is cleared by the flush with no fetch issued.
- R9: A retirement strobe clears the lane's status bit and sets its prime bit, which is then fetched and cleared like a software prime.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register word address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data for `regAddr` (combinational) |
| fetchReq | output | 1 | Descriptor fetch request |
| fetchAck | input | 1 | Fetch done; the lane is primed |
| fetchEp | output | 2 | Endpoint of the current request |
| fetchIsTx | output | 1 | Request is for the transmit lane |
| retireStb | input | 1 | Descriptor retired; re-prime this lane |
| retireEp | input | 2 | Endpoint of the retirement |
| retireIsTx | input | 1 | Retirement is on the transmit lane |
| pktBusyTx | input | 4 | Packet in flight, transmit lanes |
| pktBusyRx | input | 4 | Packet in flight, receive lanes |
| flushTx | output | 4 | Discard pulse, transmit lanes |
| flushRx | output | 4 | Discard pulse, receive lanes |

## Verification
The bench sets several prime bits with a single write and then reads the acknowledge order. A wrong priority encoder would serve the receive lane or the higher endpoint first. It holds a lane busy across a flush, then releases it. A design that ignores the packet engine would discard early and clear the status bit while the packet is still on the wire. It also sets a flush and a prime on the same lane with the fetch engine stalled, and raises a retirement on a primed lane. A design that lets the prime win would issue a fetch for a flushed lane, and one that mishandles retirement would leave the status bit set or never re-request. A long random phase with a behavioural model checked every cycle covers the collisions between acknowledge, retirement, software writes and flush.

// File: rtl/epreq_pkg.sv
package epreq_pkg;
  localparam int unsigned EP_NUM   = 4;
  localparam int unsigned LANE_NUM = 2 * EP_NUM;
  localparam int unsigned EP_W     = (EP_NUM > 1) ? $clog2(EP_NUM) : 1;
  localparam int unsigned LANE_W   = $clog2(LANE_NUM);

  // lanes [EP_NUM-1:0] are receive, [LANE_NUM-1:EP_NUM] are transmit
  typedef logic [LANE_NUM-1:0] laneVec_t;

  typedef struct packed {
    logic              ackStb;
    logic [LANE_W-1:0] ackLane;
    laneVec_t          flushGo;
  } ctrlStrobe_t;

  function automatic logic [LANE_W-1:0] laneOf(input logic [EP_W-1:0] ep, input logic isTx);
    return isTx ? (LANE_W'(EP_NUM) + LANE_W'(ep)) : LANE_W'(ep);
  endfunction
endpackage

// File: rtl/epreq_ctrl.sv
module epreq_ctrl
  import epreq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  laneVec_t          primeQ,
  input  laneVec_t          flushQ,
  input  laneVec_t          pktBusy,
  input  logic              fetchAck,
  output logic              fetchReq,
  output logic [LANE_W-1:0] fetchLane,
  output ctrlStrobe_t       strobe
);
  logic              reqQ;
  logic [LANE_W-1:0] laneQ;
  laneVec_t          eligible;
  laneVec_t          outstanding;
  logic              found;
  logic [LANE_W-1:0] pickLane;

  // a lane with a flush pending is never offered (flush wins)
  assign eligible = primeQ & ~flushQ;

  // priority walk: ep0 tx, ep0 rx, ep1 tx, ep1 rx, ...
  always_comb begin
    found    = 1'b0;
    pickLane = '0;
    for (int k = 0; k < LANE_NUM; k++) begin
      logic [LANE_W-1:0] ln;
      ln = ((k % 2) == 0) ? LANE_W'(EP_NUM + k / 2) : LANE_W'(k / 2);
      if (!found && eligible[ln]) begin
        found    = 1'b1;
        pickLane = ln;
      end
    end
  end

  assign outstanding = reqQ ? (laneVec_t'(1) << laneQ) : '0;

  always_comb begin
    strobe.ackStb  = reqQ & fetchAck;
    strobe.ackLane = laneQ;
    strobe.flushGo = flushQ & ~pktBusy & ~outstanding;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqQ  <= 1'b0;
      laneQ <= '0;
    end else if (reqQ && fetchAck) begin
      reqQ <= 1'b0;
    end else if (!reqQ && found) begin
      reqQ  <= 1'b1;
      laneQ <= pickLane;
    end
  end

  assign fetchReq  = reqQ;
  assign fetchLane = laneQ;
endmodule

// File: rtl/epreq_dp.sv
module epreq_dp
  import epreq_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned TX_BASE = 16,
  parameter int unsigned RX_BASE = 0,
  parameter logic [ADDR_W-1:0] PRIME_ADDR  = ADDR_W'(0),
  parameter logic [ADDR_W-1:0] FLUSH_ADDR  = ADDR_W'(1),
  parameter logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              retireStb,
  input  logic [LANE_W-1:0] retireLane,
  input  ctrlStrobe_t       strobe,
  output laneVec_t          primeQ,
  output laneVec_t          flushQ,
  output laneVec_t          primedQ
);
  localparam logic [DATA_W-1:0] LIVE_MASK =
      (DATA_W'({EP_NUM{1'b1}}) << RX_BASE) | (DATA_W'({EP_NUM{1'b1}}) << TX_BASE);

  laneVec_t wrLanes, rdVec, retireMask, ackMask;
  laneVec_t primeD, flushD, primedD;
  logic     primeWr, flushWr;
  logic     unusedRsvBits;

  assign wrLanes       = {regWrData[TX_BASE +: EP_NUM], regWrData[RX_BASE +: EP_NUM]};
  assign unusedRsvBits = ^(regWrData & ~LIVE_MASK);

  assign primeWr    = regWrEn && (regAddr == PRIME_ADDR);
  assign flushWr    = regWrEn && (regAddr == FLUSH_ADDR);
  assign retireMask = retireStb ? (laneVec_t'(1) << retireLane) : '0;
  assign ackMask    = strobe.ackStb ? (laneVec_t'(1) << strobe.ackLane) : '0;

  // order: completion clears, new requests set, flush clears last
  assign primeD  = ((primeQ & ~ackMask) | (primeWr ? wrLanes : '0) | retireMask) & ~strobe.flushGo;
  assign flushD  = (flushQ & ~strobe.flushGo) | (flushWr ? wrLanes : '0);
  assign primedD = ((primedQ & ~retireMask) | ackMask) & ~strobe.flushGo;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      primeQ  <= '0;
      flushQ  <= '0;
      primedQ <= '0;
    end else begin
      primeQ  <= primeD;
      flushQ  <= flushD;
      primedQ <= primedD;
    end
  end

  always_comb begin
    if (regAddr == PRIME_ADDR)       rdVec = primeQ;
    else if (regAddr == FLUSH_ADDR)  rdVec = flushQ;
    else if (regAddr == STATUS_ADDR) rdVec = primedQ;
    else                             rdVec = '0;
  end

  assign regRdData = (DATA_W'(rdVec[EP_NUM-1:0]) << RX_BASE)
                   | (DATA_W'(rdVec[LANE_NUM-1:EP_NUM]) << TX_BASE);
endmodule

// File: rtl/epreq_top.sv
module epreq_top
  import epreq_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned TX_BASE = 16,
  parameter int unsigned RX_BASE = 0,
  parameter logic [ADDR_W-1:0] PRIME_ADDR  = ADDR_W'(0),
  parameter logic [ADDR_W-1:0] FLUSH_ADDR  = ADDR_W'(1),
  parameter logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              fetchReq,
  input  logic              fetchAck,
  output logic [EP_W-1:0]   fetchEp,
  output logic              fetchIsTx,
  input  logic              retireStb,
  input  logic [EP_W-1:0]   retireEp,
  input  logic              retireIsTx,
  input  logic [EP_NUM-1:0] pktBusyTx,
  input  logic [EP_NUM-1:0] pktBusyRx,
  output logic [EP_NUM-1:0] flushTx,
  output logic [EP_NUM-1:0] flushRx
);
  laneVec_t          primeQ, flushQ, primedQ, pktBusy;
  ctrlStrobe_t       strobe;
  logic [LANE_W-1:0] fetchLane, retireLane, laneOffs;

  assign pktBusy    = {pktBusyTx, pktBusyRx};
  assign retireLane = laneOf(retireEp, retireIsTx);

  epreq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .primeQ   (primeQ),
    .flushQ   (flushQ),
    .pktBusy  (pktBusy),
    .fetchAck (fetchAck),
    .fetchReq (fetchReq),
    .fetchLane(fetchLane),
    .strobe   (strobe)
  );

  epreq_dp #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .TX_BASE(TX_BASE), .RX_BASE(RX_BASE),
    .PRIME_ADDR(PRIME_ADDR), .FLUSH_ADDR(FLUSH_ADDR), .STATUS_ADDR(STATUS_ADDR)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .retireStb (retireStb),
    .retireLane(retireLane),
    .strobe    (strobe),
    .primeQ    (primeQ),
    .flushQ    (flushQ),
    .primedQ   (primedQ)
  );

  assign fetchIsTx = (fetchLane >= LANE_W'(EP_NUM));
  assign laneOffs  = fetchIsTx ? (fetchLane - LANE_W'(EP_NUM)) : fetchLane;
  assign fetchEp   = EP_W'(laneOffs);
  assign flushTx   = strobe.flushGo[LANE_NUM-1:EP_NUM];
  assign flushRx   = strobe.flushGo[EP_NUM-1:0];
endmodule

// File: rtl/epreq_chk.sv
module epreq_chk
  import epreq_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TX_BASE = 16,
  parameter int unsigned RX_BASE = 0
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [DATA_W-1:0] regRdData,
  input logic              retireStb,
  input logic              fetchReq,
  input logic              fetchAck,
  input logic [EP_W-1:0]   fetchEp,
  input logic              fetchIsTx,
  input logic [LANE_W-1:0] fetchLane,
  input laneVec_t          pktBusy,
  input laneVec_t          primeQ,
  input laneVec_t          flushQ,
  input laneVec_t          primedQ
);
  localparam logic [DATA_W-1:0] LIVE_MASK =
      (DATA_W'({EP_NUM{1'b1}}) << RX_BASE) | (DATA_W'({EP_NUM{1'b1}}) << TX_BASE);

  // R2: unmapped bits always read zero
  p_rsv_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData & ~LIVE_MASK) == '0);

  // R4: request holds steady until acknowledged
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq && !fetchAck |=> fetchReq && $stable(fetchEp) && $stable(fetchIsTx));

  // R4: request drops after acknowledge
  p_req_drop_r4: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq && fetchAck |=> !fetchReq);

  // R4: acknowledge clears prime and sets status on that lane
  p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq && fetchAck && !retireStb && !regWrEn
      |=> !primeQ[$past(fetchLane)] && primedQ[$past(fetchLane)]);

  // R8: a new grant only goes to a lane primed and not flushing
  p_grant_clean_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fetchReq) |-> (($past(primeQ) & ~$past(flushQ) & (laneVec_t'(1) << fetchLane)) != '0));

  for (genvar l = 0; l < LANE_NUM; l++) begin : g_lane
    // R6: an unblocked flush completes and clears the lane
    p_flush_done_r6: assert property (@(posedge clk) disable iff (!rstN)
      flushQ[l] && !pktBusy[l] && !(fetchReq && fetchLane == LANE_W'(l)) && !regWrEn && !retireStb
        |=> !flushQ[l] && !primeQ[l] && !primedQ[l]);

    // R7: a flush is held while the lane is busy
    p_flush_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
      flushQ[l] && pktBusy[l] |=> flushQ[l]);
  end
endmodule

bind epreq_top epreq_chk #(
  .DATA_W(DATA_W), .TX_BASE(TX_BASE), .RX_BASE(RX_BASE)
) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdData(regRdData),
  .retireStb(retireStb), .fetchReq(fetchReq), .fetchAck(fetchAck),
  .fetchEp(fetchEp), .fetchIsTx(fetchIsTx), .fetchLane(fetchLane),
  .pktBusy(pktBusy), .primeQ(primeQ), .flushQ(flushQ), .primedQ(primedQ)
);

// File: tb/sim_epreq_top.sv
module sim_epreq_top;
  import epreq_pkg::*;
  localparam int PERIOD  = 10;
  localparam int N       = EP_NUM;
  localparam int ACK_LAT = 2;

  logic        clk = 1'b0, rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWrData = '0, regRdData;
  logic        fetchReq, fetchAck = 1'b0, fetchIsTx;
  logic [EP_W-1:0] fetchEp, retireEp = '0;
  logic        retireStb = 1'b0, retireIsTx = 1'b0;
  logic [N-1:0] pktBusyTx = '0, pktBusyRx = '0, flushTx, flushRx;

  int nCmp = 0, nBad = 0;
  bit done = 0, ackAuto = 0;
  int ackCnt = 0;
  int ackLog[$];

  // behavioural model state, index: receive ep e -> e, transmit ep e -> N+e
  int mPrime[2*N], mFlush[2*N], mPrimed[2*N];
  int mReq = 0, mLane = 0;

  epreq_top u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .fetchReq(fetchReq),
    .fetchAck(fetchAck), .fetchEp(fetchEp), .fetchIsTx(fetchIsTx),
    .retireStb(retireStb), .retireEp(retireEp), .retireIsTx(retireIsTx),
    .pktBusyTx(pktBusyTx), .pktBusyRx(pktBusyRx), .flushTx(flushTx), .flushRx(flushRx)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic int bitPos(int l);
    return (l >= N) ? 16 + (l - N) : l;
  endfunction

  function automatic int busyOf(int l);
    return (l >= N) ? int'(pktBusyTx[l-N]) : int'(pktBusyRx[l]);
  endfunction

  function automatic int goOf(int l);
    return (mFlush[l] != 0 && busyOf(l) == 0 && !(mReq != 0 && mLane == l)) ? 1 : 0;
  endfunction

  function automatic logic [31:0] modelRead(logic [3:0] a);
    logic [31:0] r = '0;
    for (int l = 0; l < 2*N; l++) begin
      if (a == 0 && mPrime[l] != 0)  r[bitPos(l)] = 1'b1;
      if (a == 1 && mFlush[l] != 0)  r[bitPos(l)] = 1'b1;
      if (a == 2 && mPrimed[l] != 0) r[bitPos(l)] = 1'b1;
    end
    return r;
  endfunction

  always @(posedge clk) begin : model
    int go[2*N];
    int win, rl, ack;
    if (!rstN) begin
      for (int l = 0; l < 2*N; l++) begin mPrime[l] = 0; mFlush[l] = 0; mPrimed[l] = 0; end
      mReq = 0; mLane = 0;
    end else begin
      for (int l = 0; l < 2*N; l++) go[l] = goOf(l);
      win = -1;
      if (mReq == 0)
        for (int e = 0; e < N; e++) begin
          if (win < 0 && mPrime[N+e] != 0 && mFlush[N+e] == 0) win = N + e;
          if (win < 0 && mPrime[e] != 0 && mFlush[e] == 0) win = e;
        end
      ack = (mReq != 0 && fetchAck) ? 1 : 0;
      rl  = retireIsTx ? N + int'(retireEp) : int'(retireEp);
      if (retireStb) mPrimed[rl] = 0;
      if (ack != 0) begin mPrime[mLane] = 0; mPrimed[mLane] = 1; end
      if (regWrEn && regAddr == 0)
        for (int l = 0; l < 2*N; l++) if (regWrData[bitPos(l)]) mPrime[l] = 1;
      if (retireStb) mPrime[rl] = 1;
      for (int l = 0; l < 2*N; l++)
        if (go[l] != 0) begin mFlush[l] = 0; mPrime[l] = 0; mPrimed[l] = 0; end
      if (regWrEn && regAddr == 1)
        for (int l = 0; l < 2*N; l++) if (regWrData[bitPos(l)]) mFlush[l] = 1;
      if (ack != 0) mReq = 0;
      else if (mReq == 0 && win >= 0) begin mReq = 1; mLane = win; end
    end
  end

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (rstN) begin
      cmp("R4 fetchReq", 32'(fetchReq), 32'(mReq));
      if (mReq != 0) begin
        cmp("R5 fetchEp", 32'(fetchEp), 32'((mLane >= N) ? mLane - N : mLane));
        cmp("R5 fetchIsTx", 32'(fetchIsTx), 32'((mLane >= N) ? 1 : 0));
      end
      for (int e = 0; e < N; e++) begin
        cmp("R6 flushTx", 32'(flushTx[e]), 32'(goOf(N+e)));
        cmp("R6 flushRx", 32'(flushRx[e]), 32'(goOf(e)));
      end
      cmp("R2 regRdData", regRdData, modelRead(regAddr));
      if (fetchReq && fetchAck) ackLog.push_back(int'(fetchEp) * 2 + int'(fetchIsTx));
    end
  end

  // fetch engine responder
  always @(negedge clk) begin
    if (ackAuto) begin
      if (fetchAck) begin fetchAck = 1'b0; ackCnt = 0; end
      else if (fetchReq) begin
        if (ackCnt >= ACK_LAT) fetchAck = 1'b1;
        else ackCnt++;
      end
    end
  end

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rd(logic [3:0] a, logic [31:0] exp, string tag);
    @(negedge clk); regAddr = a; #2;
    cmp(tag, regRdData, exp);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rd(0, 0, "R1 prime after reset");
    rd(1, 0, "R1 flush after reset");
    rd(2, 0, "R1 status after reset");
    cmp("R1 fetchReq after reset", 32'(fetchReq), 0);
    // R2 reserved bits and unmapped address
    wr(0, 32'hFFF0_FFF0); rd(0, 0, "R2 prime reserved bits");
    wr(1, 32'hFFF0_FFF0); rd(1, 0, "R2 flush reserved bits");
    rd(7, 0, "R2 unmapped address");
    // R3 write-one set, write-zero no effect, status read-only
    wr(0, 32'h0002_0000); rd(0, 32'h0002_0000, "R3 prime set tx ep1");
    cmp("R4 request raised", 32'(fetchReq), 1);
    cmp("R4 request ep", 32'(fetchEp), 1);
    cmp("R4 request tx", 32'(fetchIsTx), 1);
    wr(0, 32'h0); rd(0, 32'h0002_0000, "R3 zero write no effect");
    wr(2, 32'hFFFF_FFFF); rd(2, 0, "R3 status write ignored");
    repeat (3) @(negedge clk);
    cmp("R4 request held", 32'(fetchReq), 1);
    @(negedge clk); fetchAck = 1'b1;
    @(negedge clk); fetchAck = 1'b0; #2;
    cmp("R4 request dropped after ack", 32'(fetchReq), 0);
    rd(0, 0, "R4 prime cleared by ack");
    rd(2, 32'h0002_0000, "R4 status set by ack");
    // R5 service order
    ackLog.delete(); ackAuto = 1;
    wr(0, 32'h0003_0002);
    repeat (20) @(negedge clk);
    cmp("R5 ack count", 32'(ackLog.size()), 3);
    if (ackLog.size() == 3) begin
      cmp("R5 first ep0 tx", 32'(ackLog[0]), 1);
      cmp("R5 second ep1 tx", 32'(ackLog[1]), 3);
      cmp("R5 third ep1 rx", 32'(ackLog[2]), 2);
    end
    rd(2, 32'h0003_0002, "R5 status after order test");
    // R7 flush held while busy, R6 discard
    @(negedge clk); pktBusyRx = 4'b0010;
    wr(1, 32'h0000_0002);
    repeat (4) @(negedge clk);
    rd(1, 32'h0000_0002, "R7 flush held while busy");
    rd(2, 32'h0003_0002, "R7 status kept while busy");
    cmp("R7 no discard while busy", 32'(flushRx), 0);
    @(negedge clk); pktBusyRx = '0; #2;
    cmp("R6 discard pulse rx ep1", 32'(flushRx), 32'h2);
    rd(1, 0, "R6 flush bit cleared");
    rd(2, 32'h0003_0000, "R6 status cleared");
    // R8 flush wins over a prime on the same lane
    ackAuto = 0;
    @(negedge clk); pktBusyTx = 4'b0100;
    wr(1, 32'h0004_0000);
    wr(0, 32'h0004_0000);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); #2;
      cmp("R8 no fetch while flush pending", 32'(fetchReq), 0);
    end
    rd(0, 32'h0004_0000, "R8 prime pending under flush");
    @(negedge clk); pktBusyTx = '0;
    rd(0, 0, "R8 prime cleared by flush");
    rd(1, 0, "R8 flush done");
    cmp("R8 no fetch issued", 32'(fetchReq), 0);
    // R9 retirement re-primes
    @(negedge clk); retireStb = 1'b1; retireEp = 0; retireIsTx = 1'b1;
    @(negedge clk); retireStb = 1'b0;
    rd(0, 32'h0001_0000, "R9 prime raised by retire");
    rd(2, 32'h0002_0000, "R9 status cleared by retire");
    cmp("R9 refetch requested", 32'(fetchReq), 1);
    cmp("R9 refetch ep0", 32'(fetchEp), 0);
    cmp("R9 refetch tx", 32'(fetchIsTx), 1);
    ackAuto = 1;
    repeat (8) @(negedge clk);
    rd(0, 0, "R9 prime cleared after refetch");
    rd(2, 32'h0003_0000, "R9 status restored");
    // mixed traffic against the model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      regWrEn    = ($urandom % 4) == 0;
      regAddr    = 4'($urandom % 4);
      regWrData  = $urandom;
      retireStb  = ($urandom % 8) == 0;
      retireEp   = EP_W'($urandom);
      retireIsTx = 1'($urandom);
      pktBusyTx  = N'($urandom & $urandom);
      pktBusyRx  = N'($urandom & $urandom);
    end
    @(negedge clk);
    regWrEn = 0; retireStb = 0; pktBusyTx = '0; pktBusyRx = '0;
    repeat (40) @(negedge clk);
    rd(1, 0, "R6 all flushes drained");
    rd(0, 0, "R4 all primes served");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL R4 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end
endmodule